// File: doc/BRIEF.md
# Synchronizable PWM Ramp Generator

This block is the digital core of a voltage-mode buck controller's modulator. A counter stands in for a sawtooth oscillator. Each switching period has two parts: a ramp phase that counts up from zero, then a forced off-time of fixed length. During the ramp the gate output is high while the count is below a latched duty command. The period length comes from a configuration input. An external sync signal can cut the ramp short, so the switching frequency follows a faster outside clock.

A rising edge on the sync input passes through a two-flop synchronizer and an edge detector. If the edge arrives during the ramp, the ramp ends at once. The off-time then follows and a new period begins. If the edge arrives during the off-time, it is held. It then marks that period as ended by sync, and the off-time is neither cut short nor lengthened.

A cycle-start strobe marks the first clock of every period. A lock flag shows whether the last periods were ended by sync edges. The counter width comes from the system clock rate and the lowest switching frequency, so the slowest required period fits.

Top module: `pwm_ramp_gen`

## Requirements
- R1: During reset, pwm_gate, cycle_start and sync_locked are low. The first cycle_start appears OFF_CYCLES clocks after reset is released.
- R2: With no sync activity, cycle_start pulses exactly P clocks apart, where P is the period_cfg value latched at period start. Any value of OFF_CYCLES or less gives a period of OFF_CYCLES+1 clocks.
- R3: pwm_gate is high on the first D clocks of a period, starting with the clock that carries cycle_start. D is the latched duty_cmd, limited to the ramp length. pwm_gate rises only together with cycle_start.
- R4: A duty_cmd of zero gives no gate pulse at all in that period.
- R5: The last OFF_CYCLES clocks of every period have pwm_gate low. With a free-running period P, the longest on-time is therefore P-OFF_CYCLES clocks.
- R6: duty_cmd and period_cfg are sampled only at the clock that starts a period. Changing them in the middle of a period does not affect that period.
- R7: A sync_in rising edge during the ramp ends the ramp. The next cycle_start comes OFF_CYCLES+3 clocks after the clock in which sync_in first reads high.
- R8: A sync_in rising edge during the off-time leaves the period length unchanged. That period still counts as ended by sync.
- R9: Only rising edges of sync_in matter. Holding sync_in high, or changing the width of its high phase, has no further effect.
- R10: sync_locked rises at the cycle_start that follows the second consecutive period ended by sync. It falls at the cycle_start that follows a period ended by timeout. It changes only together with cycle_start.
- R11: A period of CLK_HZ/FMIN_HZ clocks (500 at the defaults, 100 kHz at 50 MHz) is accepted and honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cfg | input | CNT_W | Free-running period in clocks, off-time included |
| duty_cmd | input | CNT_W | Gate on-time in clocks for the next period |
| sync_in | input | 1 | Asynchronous external sync; its rising edges end the ramp |
| pwm_gate | output | 1 | Gate drive for the power switch |
| cycle_start | output | 1 | One-clock strobe on the first clock of each period |
| sync_locked | output | 1 | High after two consecutive periods ended by sync |

## Verification
The free-running case is tried with zero, mid-range and saturating duty commands, and with degenerate and full-range periods. These runs separate the gate compare from the off-time clamp.

Sync pulse trains are tried with narrow and very wide high phases. One train is placed so that its edges fall inside the off-time. A held-high level is also applied. Together these distinguish edge detection from level sensing, and show whether an edge that arrives late is held rather than lost.

A duty change in the middle of a period shows whether the value is latched. Long constrained-random runs mix random periods, duties and sync trains, and a cycle-level reference model checks every output on every clock.

// File: rtl/pwm_ramp_pkg.sv
package pwm_ramp_pkg;

    // Phase of the switching period: counting ramp or forced off-time.
    typedef enum logic {
        PH_RAMP = 1'b0,
        PH_OFF  = 1'b1
    } ramp_phase_e;

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_raw,
    output logic rise_pulse
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], sync_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Newest synchronized sample high, previous one low.
    assign rise_pulse = st_q.chain[CHAIN_W-2] & ~st_q.chain[CHAIN_W-1];

    // R9
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/ramp_core.sv
module ramp_core
    import pwm_ramp_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int OFF_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_cfg,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic             sync_rise,
    output logic             pwm_gate,
    output logic             cycle_start,
    output logic             period_done,
    output logic             done_by_sync
);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] OFF_VAL  = CNT_W'(OFF_CYCLES);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYCLES - 1);

    typedef struct packed {
        ramp_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] period;
        logic             seen;
        logic             start;
    } core_state_t;

    core_state_t      st_d, st_q;
    logic [CNT_W-1:0] ramp_last;

    // Last ramp count for a timeout end; the off-time fills the rest of the period.
    always_comb begin
        if (st_q.period > OFF_VAL) ramp_last = st_q.period - OFF_VAL - ONE;
        else                       ramp_last = '0;
    end

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (st_q.phase == PH_RAMP) begin
            if (sync_rise || (st_q.cnt == ramp_last)) begin
                st_d.phase = PH_OFF;
                st_d.cnt   = '0;
                st_d.seen  = st_q.seen | sync_rise;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end else begin
            st_d.seen = st_q.seen | sync_rise;
            if (st_q.cnt == OFF_LAST) begin
                st_d.phase  = PH_RAMP;
                st_d.cnt    = '0;
                st_d.duty   = duty_cmd;
                st_d.period = period_cfg;
                st_d.seen   = 1'b0;
                st_d.start  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_gate     = (st_q.phase == PH_RAMP) && (st_q.cnt < st_q.duty);
    assign cycle_start  = st_q.start;
    assign period_done  = (st_q.phase == PH_OFF) && (st_q.cnt == OFF_LAST);
    assign done_by_sync = st_q.seen | sync_rise;

    // R5
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_OFF && st_q.cnt != OFF_LAST) |=> (st_q.phase == PH_OFF));

    // R5
    start_after_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> ($past(st_q.phase) == PH_OFF && $past(st_q.cnt) == OFF_LAST));

    // R3
    gate_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_gate) |-> cycle_start);

    // R2
    ramp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RAMP) |-> (st_q.cnt <= ramp_last));

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |-> ($stable(st_q.duty) && $stable(st_q.period)));

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker #(
    parameter int LOCK_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_done,
    input  logic done_by_sync,
    output logic locked
);
    localparam int              RUN_W   = $clog2(LOCK_PERIODS + 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_PERIODS);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             locked;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (period_done) begin
            if (!done_by_sync)         st_d.run = '0;
            else if (st_q.run != RUN_TOP) st_d.run = st_q.run + RUN_W'(1);
            st_d.locked = (st_d.run == RUN_TOP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.locked;

    // R10
    lock_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(locked) || $fell(locked)) |-> $past(period_done));

    // R10
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_done && !done_by_sync) |=> !locked);

endmodule

// File: rtl/pwm_ramp_gen.sv
module pwm_ramp_gen #(
    parameter int CLK_HZ       = 50_000_000,
    parameter int FMIN_HZ      = 100_000,
    parameter int OFF_CYCLES   = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int LOCK_PERIODS = 2,
    parameter int CNT_W        = $clog2(CLK_HZ / FMIN_HZ + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_cfg,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic             sync_in,
    output logic             pwm_gate,
    output logic             cycle_start,
    output logic             sync_locked
);
    logic sync_rise;
    logic period_done;
    logic done_by_sync;

    sync_edge_det #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_raw   (sync_in),
        .rise_pulse (sync_rise)
    );

    ramp_core #(
        .CNT_W      (CNT_W),
        .OFF_CYCLES (OFF_CYCLES)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_cfg   (period_cfg),
        .duty_cmd     (duty_cmd),
        .sync_rise    (sync_rise),
        .pwm_gate     (pwm_gate),
        .cycle_start  (cycle_start),
        .period_done  (period_done),
        .done_by_sync (done_by_sync)
    );

    lock_tracker #(
        .LOCK_PERIODS (LOCK_PERIODS)
    ) u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_done  (period_done),
        .done_by_sync (done_by_sync),
        .locked       (sync_locked)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!pwm_gate && !cycle_start && !sync_locked) || !rst_n);

endmodule

// File: tb/pwm_ramp_gen_test.sv
module pwm_ramp_gen_test;
    localparam int CW  = 9;
    localparam int OFF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_in = 1'b0;
    logic [CW-1:0] period_cfg = CW'(50);
    logic [CW-1:0] duty_cmd = CW'(20);
    logic          pwm_gate, cycle_start, sync_locked;

    always #10 clk = ~clk;

    pwm_ramp_gen #(
        .CLK_HZ(50_000_000), .FMIN_HZ(100_000), .OFF_CYCLES(OFF),
        .SYNC_STAGES(2), .LOCK_PERIODS(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .period_cfg(period_cfg), .duty_cmd(duty_cmd),
        .sync_in(sync_in), .pwm_gate(pwm_gate), .cycle_start(cycle_start),
        .sync_locked(sync_locked)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model written from the requirements: cycle position in period.
    int m_s1, m_s2, m_s3, m_in_off, m_pos, m_offc, m_duty, m_per, m_seen, m_run, m_lock, m_start;

    function automatic int last_ramp(int per);
        return (per > OFF) ? per - OFF - 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_in_off = 1; m_pos = 0; m_offc = 0;
            m_duty = 0; m_per = 0; m_seen = 0; m_run = 0; m_lock = 0; m_start = 0;
        end else begin
            int rise;
            rise = m_s2 & ~m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(sync_in);
            m_start = 0;
            if (!m_in_off) begin
                if (rise != 0 || m_pos == last_ramp(m_per)) begin
                    m_in_off = 1; m_offc = 0; m_seen = m_seen | rise;
                end else m_pos++;
            end else begin
                m_seen = m_seen | rise;
                if (m_offc == OFF - 1) begin
                    m_run = m_seen ? ((m_run < 2) ? m_run + 1 : 2) : 0;
                    m_lock = (m_run == 2);
                    m_in_off = 0; m_pos = 0; m_seen = 0; m_start = 1;
                    m_duty = int'(duty_cmd); m_per = int'(period_cfg);
                end else m_offc++;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3/R4/R5/R6 gate vs model", int'(pwm_gate), (!m_in_off && m_pos < m_duty) ? 1 : 0);
            check("R2/R7/R8/R9 start vs model", int'(cycle_start), m_start);
            check("R10 lock vs model", int'(sync_locked), m_lock);
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL all requirements: watchdog actual=%0d expected<%0d", cyc, 190000);
            summary();
            $finish;
        end
    end

    task automatic wait_start();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!cycle_start && guard < 2000);
    endtask

    // Called on a negedge with cycle_start high; returns period length and on-count.
    task automatic period_stats(output int gap, output int on);
        on = int'(pwm_gate);
        gap = 0;
        forever begin
            @(negedge clk);
            gap++;
            if (cycle_start || gap > 2000) break;
            on += int'(pwm_gate);
        end
    endtask

    task automatic sync_train(int sper, int width, int n);
        for (int i = 0; i < n * sper; i++) begin
            sync_in = ((i % sper) < width);
            @(negedge clk);
        end
        sync_in = 1'b0;
    endtask

    initial begin
        int gap, on, n;
        void'($urandom(32'h1234_5EED));
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 gate in reset", int'(pwm_gate), 0);
        check("R1 start in reset", int'(cycle_start), 0);
        check("R1 lock in reset", int'(sync_locked), 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!cycle_start && n < 100);
        check("R1 first start delay", n, OFF);

        // R2/R3 free running
        period_stats(gap, on);
        check("R2 period 50", gap, 50);
        check("R3 on-time 20", on, 20);
        duty_cmd = '0;
        wait_start(); period_stats(gap, on);
        check("R4 zero duty on-time", on, 0);
        duty_cmd = CW'(500);
        wait_start(); period_stats(gap, on);
        check("R5 max on-time", on, 50 - OFF);
        period_cfg = CW'(5);
        wait_start(); wait_start(); period_stats(gap, on);
        check("R2 short period floor", gap, OFF + 1);
        check("R5 short period on-time", on, 1);
        period_cfg = CW'(500); duty_cmd = CW'(100);
        wait_start(); wait_start(); period_stats(gap, on);
        check("R11 full-range period", gap, 500);

        // R6 mid-period changes
        period_cfg = CW'(60); duty_cmd = CW'(30);
        wait_start();
        on = int'(pwm_gate); gap = 0;
        forever begin
            @(negedge clk); gap++;
            if (gap == 5) begin duty_cmd = CW'(2); period_cfg = CW'(90); end
            if (cycle_start || gap > 2000) break;
            on += int'(pwm_gate);
        end
        check("R6 old duty kept", on, 30);
        check("R6 old period kept", gap, 60);
        period_stats(gap, on);
        check("R6 new duty applied", on, 2);
        check("R6 new period applied", gap, 90);

        // R7 latency, then R9 held high level
        period_cfg = CW'(200); duty_cmd = CW'(40);
        wait_start(); wait_start();
        repeat (50) @(negedge clk);
        sync_in = 1'b1;
        gap = 50;
        do begin @(negedge clk); gap++; end while (!cycle_start && gap < 2000);
        check("R7 sync-ended period", gap, 50 + OFF + 3);
        period_stats(gap, on);
        check("R9 held level does not retrigger", gap, 200);
        sync_in = 1'b0;

        // R7/R10 locked train, narrow and wide pulses
        for (int w = 0; w < 2; w++) begin
            fork
                sync_train(100, (w == 0) ? 3 : 70, 8);
                begin
                    repeat (4) wait_start();
                    check("R10 locked on train", int'(sync_locked), 1);
                    period_stats(gap, on);
                    check(w == 0 ? "R7 train period" : "R9 wide pulse period", gap, 100);
                end
            join
            repeat (3) wait_start();
            check("R10 unlock after timeout", int'(sync_locked), 0);
            period_stats(gap, on);
            check("R10 free period after train", gap, 200);
        end

        // R8 edges placed inside the off-time
        period_cfg = CW'(40); duty_cmd = CW'(10);
        wait_start(); wait_start();
        for (int k = 0; k < 5; k++) begin
            gap = 0;
            forever begin
                @(negedge clk); gap++;
                if (gap == 40 - OFF) sync_in = 1'b1;
                if (gap == 40 - OFF + 2) sync_in = 1'b0;
                if (cycle_start || gap > 2000) break;
            end
            if (k > 0) check("R8 period unchanged", gap, 40);
        end
        check("R8 off-time edges keep lock", int'(sync_locked), 1);

        // Random segments checked by the model
        for (int s = 0; s < 30; s++) begin
            int sp, wd, mode;
            period_cfg = CW'($urandom_range(400, 20));
            duty_cmd = CW'($urandom_range(450, 0));
            sp = $urandom_range(300, 30);
            wd = $urandom_range(sp - 1, 1);
            mode = $urandom_range(2, 0);
            for (int i = 0; i < 1500; i++) begin
                sync_in = (mode != 0) && ((i % sp) < wd);
                if ($urandom_range(49, 0) == 0) duty_cmd = CW'($urandom_range(450, 0));
                @(negedge clk);
            end
            sync_in = 1'b0;
        end

        done = 1;
        summary();
        $finish;
    end
endmodule